// File: doc/BRIEF.md
# Prioritized GPIO Pin-Sharing Port

This block is an eight-pin general-purpose I/O port. Its pins are shared with two CAN controllers (a primary one, A, and a routed one, B), two two-wire serial (I2C-style) buses, a UART and a bank of four chip-select outputs. Each pin group has a fixed precedence chain. The chain decides, from the peripheral enable flags, which function owns each pin. Every pin that no peripheral claims falls back to GPIO.

Software reaches a latched data register and a direction register over a minimal register bus, and both can be accessed in any cycle. A data read returns the latched value on output bits and the live pin level on input bits. For each pin the block drives a pad output value, an output enable and an open-drain flag. It also returns the pin levels to the receive inputs of the peripherals.

Top module: `gpmux_port`

## Requirements
- R1: After reset both registers hold zero, every `pad_oe` bit is 0, and a read of the direction register returns 0.
- R2: When `bus_we` is high at a rising clock edge, `bus_wdata` is stored in the direction register if `bus_sel_dir`=1 and in the data register if `bus_sel_dir`=0. While `bus_sel_dir`=1, `bus_rdata` shows the stored direction value.
- R3: While `bus_sel_dir`=0, each bit of `bus_rdata` shows the latched data bit when its direction bit is 1, and the current `pin_in` bit when its direction bit is 0.
- R4: Bit 3 is absent. It reads 0 from both registers, ignores writes, and its `pad_oe` stays 0.
- R5: A pin owned by GPIO drives `pad_out` = data bit and `pad_oe` = direction bit, with `pad_od` = 0.
- R6: Pins 7 and 6 are owned, in order of precedence, by CAN-A, then two-wire bus 0, then CAN-B, then GPIO. A CAN owner drives its transmit value push-pull on pin 7 and leaves pin 6 undriven as its receive line.
- R7: Pins 5 and 4 are owned, in order of precedence, by two-wire bus 1, then chip select 2 (pin 5) or chip select 0 (pin 4), then GPIO. A chip select drives push-pull.
- R8: Pin 2 carries chip select 1 push-pull while `cs_en[1]` is set, and is GPIO otherwise.
- R9: With `en_uart` set, pin 1 drives `uart_tx` push-pull and pin 0 is an undriven receive input, even when `cs_en[3]` is also set. Without the UART, pin 0 carries chip select 3 while `cs_en[3]` is set.
- R10: A pin won by a two-wire bus has `pad_od`=1 and `pad_out`=0. Its `pad_oe` is the inverse of the bus output value, so the pin is pulled low for 0 and released for 1.
- R11: Each peripheral receive input equals the level of its pin while that function owns the pin, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_sel_dir | input | 1 | 1 selects the direction register, 0 selects the data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| pin_in | input | 8 | Buffered pin input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_od | output | 8 | Pad open-drain flags |
| en_can_a | input | 1 | CAN-A enable |
| can_a_tx | input | 1 | CAN-A transmit value |
| can_a_rx | output | 1 | CAN-A receive input |
| en_twi0 | input | 1 | Two-wire bus 0 enable |
| twi0_scl_o | input | 1 | Bus 0 clock output value |
| twi0_sda_o | input | 1 | Bus 0 data output value |
| twi0_scl_i | output | 1 | Bus 0 clock input |
| twi0_sda_i | output | 1 | Bus 0 data input |
| en_can_b | input | 1 | CAN-B enable |
| can_b_tx | input | 1 | CAN-B transmit value |
| can_b_rx | output | 1 | CAN-B receive input |
| en_twi1 | input | 1 | Two-wire bus 1 enable |
| twi1_scl_o | input | 1 | Bus 1 clock output value |
| twi1_sda_o | input | 1 | Bus 1 data output value |
| twi1_scl_i | output | 1 | Bus 1 clock input |
| twi1_sda_i | output | 1 | Bus 1 data input |
| cs_en | input | 4 | Per chip-select function enables |
| cs_val | input | 4 | Chip-select output values |
| en_uart | input | 1 | UART enable |
| uart_tx | input | 1 | UART transmit value |
| uart_rx | output | 1 | UART receive input |

## Verification
Each pin group is tested with one contender enabled at a time, and then with enables added from the lowest precedence upward. This tells a correct precedence chain apart from one with swapped or missing levels. Register reads are taken with mixed direction patterns and a pin pattern that differs from the latched data, so a read that returns the wrong source shows up. The two-wire cases drive opposite values on clock and data, which separates the pulled-low pin from the released one. Receive routing is checked both while the function owns its pin and after it has been displaced, to confirm the idle-high value.

// File: rtl/gpmux_pkg.sv
package gpmux_pkg;

  localparam int PORT_W = 8;
  localparam int CS_N   = 4;

  typedef enum logic [2:0] {
    OWN_GPIO, OWN_CAN_A, OWN_TWI0, OWN_CAN_B, OWN_TWI1, OWN_CSEL, OWN_UART
  } owner_e;

  typedef enum logic [1:0] {
    DRV_GPIO, DRV_PUSH, DRV_INPUT, DRV_OPEN
  } drive_e;

  typedef struct packed {
    logic            can_a;
    logic            twi0;
    logic            can_b;
    logic            twi1;
    logic            uart;
    logic [CS_N-1:0] csel;
  } fn_en_t;

  typedef struct packed {
    logic            can_a_tx;
    logic            twi0_scl;
    logic            twi0_sda;
    logic            can_b_tx;
    logic            twi1_scl;
    logic            twi1_sda;
    logic            uart_tx;
    logic [CS_N-1:0] csel;
  } fn_out_t;

  // precedence chain of each pin group
  function automatic owner_e pick_owner(input int idx, input fn_en_t en);
    owner_e r;
    case (idx)
      7, 6: begin
        if (en.can_a)     r = OWN_CAN_A;
        else if (en.twi0) r = OWN_TWI0;
        else if (en.can_b) r = OWN_CAN_B;
        else              r = OWN_GPIO;
      end
      5: r = en.twi1 ? OWN_TWI1 : (en.csel[2] ? OWN_CSEL : OWN_GPIO);
      4: r = en.twi1 ? OWN_TWI1 : (en.csel[0] ? OWN_CSEL : OWN_GPIO);
      2: r = en.csel[1] ? OWN_CSEL : OWN_GPIO;
      1: r = en.uart ? OWN_UART : OWN_GPIO;
      0: r = en.uart ? OWN_UART : (en.csel[3] ? OWN_CSEL : OWN_GPIO);
      default: r = OWN_GPIO;
    endcase
    return r;
  endfunction

  // how the owning function uses the pad
  function automatic drive_e drive_of(input int idx, input owner_e own);
    drive_e r;
    case (own)
      OWN_CAN_A, OWN_CAN_B: r = (idx == 7) ? DRV_PUSH : DRV_INPUT;
      OWN_TWI0, OWN_TWI1:   r = DRV_OPEN;
      OWN_CSEL:             r = DRV_PUSH;
      OWN_UART:             r = (idx == 1) ? DRV_PUSH : DRV_INPUT;
      default:              r = DRV_GPIO;
    endcase
    return r;
  endfunction

  // value the owning function presents to the pin
  function automatic logic value_of(input int idx, input owner_e own,
                                    input fn_out_t fo);
    logic r;
    case (own)
      OWN_CAN_A: r = fo.can_a_tx;
      OWN_CAN_B: r = fo.can_b_tx;
      OWN_TWI0:  r = (idx == 7) ? fo.twi0_scl : fo.twi0_sda;
      OWN_TWI1:  r = (idx == 5) ? fo.twi1_scl : fo.twi1_sda;
      OWN_UART:  r = fo.uart_tx;
      OWN_CSEL: begin
        case (idx)
          5:       r = fo.csel[2];
          4:       r = fo.csel[0];
          2:       r = fo.csel[1];
          default: r = fo.csel[3];
        endcase
      end
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // data read: latched value on outputs, pin level on inputs
  function automatic logic [PORT_W-1:0] merge_read(
      input logic [PORT_W-1:0] dir, input logic [PORT_W-1:0] latch,
      input logic [PORT_W-1:0] pin, input logic [PORT_W-1:0] mask);
    return ((dir & latch) | (~dir & pin)) & mask;
  endfunction

endpackage

// File: rtl/gpmux_regs.sv
module gpmux_regs
  import gpmux_pkg::*;
#(
  parameter int               W         = PORT_W,
  parameter logic [W-1:0]     IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         sel_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rdata,
  output logic         wr_data_evt,
  output logic         wr_dir_evt
);

  assign wr_data_evt = we && !sel_dir;
  assign wr_dir_evt  = we && sel_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_evt) data_q <= wdata & IMPL_MASK;
      if (wr_dir_evt)  dir_q  <= wdata & IMPL_MASK;
    end
  end

  assign rdata = sel_dir ? dir_q : merge_read(dir_q, data_q, pin_in, IMPL_MASK);

endmodule

// File: rtl/gpmux_select.sv
module gpmux_select
  import gpmux_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  fn_en_t               en,
  input  fn_out_t              fo,
  output owner_e [W-1:0]       owner,
  output drive_e [W-1:0]       kind,
  output logic   [W-1:0]       fval
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      owner[i] = pick_owner(i, en);
      kind[i]  = drive_of(i, owner[i]);
      fval[i]  = value_of(i, owner[i], fo);
    end
  end

endmodule

// File: rtl/gpmux_pad.sv
module gpmux_pad
  import gpmux_pkg::*;
(
  input  drive_e kind,
  input  logic   fval,
  input  logic   gpio_d,
  input  logic   gpio_dir,
  output logic   out,
  output logic   oe,
  output logic   od
);

  always_comb begin
    case (kind)
      DRV_PUSH: begin
        out = fval; oe = 1'b1; od = 1'b0;
      end
      DRV_INPUT: begin
        out = 1'b0; oe = 1'b0; od = 1'b0;
      end
      DRV_OPEN: begin
        out = 1'b0; oe = ~fval; od = 1'b1;
      end
      default: begin
        out = gpio_d; oe = gpio_dir; od = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/gpmux_route.sv
module gpmux_route
  import gpmux_pkg::*;
(
  input  owner_e own7,
  input  owner_e own6,
  input  owner_e own5,
  input  owner_e own4,
  input  owner_e own0,
  input  logic   pin7,
  input  logic   pin6,
  input  logic   pin5,
  input  logic   pin4,
  input  logic   pin0,
  output logic   can_a_rx,
  output logic   can_b_rx,
  output logic   twi0_scl_i,
  output logic   twi0_sda_i,
  output logic   twi1_scl_i,
  output logic   twi1_sda_i,
  output logic   uart_rx
);

  // receive lines idle high while another function holds the pin
  assign can_a_rx   = (own6 == OWN_CAN_A) ? pin6 : 1'b1;
  assign can_b_rx   = (own6 == OWN_CAN_B) ? pin6 : 1'b1;
  assign twi0_scl_i = (own7 == OWN_TWI0)  ? pin7 : 1'b1;
  assign twi0_sda_i = (own6 == OWN_TWI0)  ? pin6 : 1'b1;
  assign twi1_scl_i = (own5 == OWN_TWI1)  ? pin5 : 1'b1;
  assign twi1_sda_i = (own4 == OWN_TWI1)  ? pin4 : 1'b1;
  assign uart_rx    = (own0 == OWN_UART)  ? pin0 : 1'b1;

endmodule

// File: rtl/gpmux_port.sv
module gpmux_port
  import gpmux_pkg::*;
#(
  parameter int                  W         = PORT_W,
  parameter logic [PORT_W-1:0]   IMPL_MASK = 8'hF7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic            bus_sel_dir,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  input  logic [W-1:0]    pin_in,
  output logic [W-1:0]    pad_out,
  output logic [W-1:0]    pad_oe,
  output logic [W-1:0]    pad_od,
  input  logic            en_can_a,
  input  logic            can_a_tx,
  output logic            can_a_rx,
  input  logic            en_twi0,
  input  logic            twi0_scl_o,
  input  logic            twi0_sda_o,
  output logic            twi0_scl_i,
  output logic            twi0_sda_i,
  input  logic            en_can_b,
  input  logic            can_b_tx,
  output logic            can_b_rx,
  input  logic            en_twi1,
  input  logic            twi1_scl_o,
  input  logic            twi1_sda_o,
  output logic            twi1_scl_i,
  output logic            twi1_sda_i,
  input  logic [CS_N-1:0] cs_en,
  input  logic [CS_N-1:0] cs_val,
  input  logic            en_uart,
  input  logic            uart_tx,
  output logic            uart_rx
);

  localparam logic [W-1:0] MASK = IMPL_MASK[W-1:0];

  logic [W-1:0]   data_q;
  logic [W-1:0]   dir_q;
  logic           wr_data_evt;
  logic           wr_dir_evt;
  fn_en_t         en;
  fn_out_t        fo;
  owner_e [W-1:0] owner;
  drive_e [W-1:0] kind;
  logic   [W-1:0] fval;

  assign en = '{can_a: en_can_a, twi0: en_twi0, can_b: en_can_b,
                twi1: en_twi1, uart: en_uart, csel: cs_en};
  assign fo = '{can_a_tx: can_a_tx, twi0_scl: twi0_scl_o, twi0_sda: twi0_sda_o,
                can_b_tx: can_b_tx, twi1_scl: twi1_scl_o, twi1_sda: twi1_sda_o,
                uart_tx: uart_tx, csel: cs_val};

  gpmux_regs #(.W(W), .IMPL_MASK(MASK)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (bus_we),
    .sel_dir     (bus_sel_dir),
    .wdata       (bus_wdata),
    .pin_in      (pin_in),
    .data_q      (data_q),
    .dir_q       (dir_q),
    .rdata       (bus_rdata),
    .wr_data_evt (wr_data_evt),
    .wr_dir_evt  (wr_dir_evt)
  );

  gpmux_select #(.W(W)) u_select (
    .en    (en),
    .fo    (fo),
    .owner (owner),
    .kind  (kind),
    .fval  (fval)
  );

  for (genvar i = 0; i < W; i++) begin : g_pad
    gpmux_pad u_pad (
      .kind     (kind[i]),
      .fval     (fval[i]),
      .gpio_d   (data_q[i]),
      .gpio_dir (dir_q[i]),
      .out      (pad_out[i]),
      .oe       (pad_oe[i]),
      .od       (pad_od[i])
    );
  end

  gpmux_route u_route (
    .own7       (owner[7]),
    .own6       (owner[6]),
    .own5       (owner[5]),
    .own4       (owner[4]),
    .own0       (owner[0]),
    .pin7       (pin_in[7]),
    .pin6       (pin_in[6]),
    .pin5       (pin_in[5]),
    .pin4       (pin_in[4]),
    .pin0       (pin_in[0]),
    .can_a_rx   (can_a_rx),
    .can_b_rx   (can_b_rx),
    .twi0_scl_i (twi0_scl_i),
    .twi0_sda_i (twi0_sda_i),
    .twi1_scl_i (twi1_scl_i),
    .twi1_sda_i (twi1_sda_i),
    .uart_rx    (uart_rx)
  );

endmodule

// File: rtl/gpmux_port_chk.sv
module gpmux_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] pin_in,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_od,
  input logic       en_can_a,
  input logic       en_twi0,
  input logic       en_twi1,
  input logic       en_uart,
  input logic       uart_rx,
  input logic       twi1_scl_i,
  input logic [7:0] data_q,
  input logic [7:0] dir_q,
  input logic       wr_data_evt,
  input logic       wr_dir_evt
);

  // R2
  wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_evt |=> (data_q == ($past(bus_wdata) & 8'hF7)));

  // R2
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_evt |=> (dir_q == ($past(bus_wdata) & 8'hF7)));

  // R4
  bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rdata[3] && !pad_oe[3]));

  // R10
  od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_od & pad_out) == 8'h00));

  // R6
  prio76_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_od[7] |-> (en_twi0 && !en_can_a));

  // R6
  cana_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_can_a |-> (pad_oe[7] && !pad_oe[6] && (pad_od[7:6] == 2'b00)));

  // R9
  uart_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_uart |-> ((uart_rx == pin_in[0]) && !pad_oe[0]));

  // R11
  twi1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_twi1 |-> twi1_scl_i);

endmodule

bind gpmux_port gpmux_port_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pin_in      (pin_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_od      (pad_od),
  .en_can_a    (en_can_a),
  .en_twi0     (en_twi0),
  .en_twi1     (en_twi1),
  .en_uart     (en_uart),
  .uart_rx     (uart_rx),
  .twi1_scl_i  (twi1_scl_i),
  .data_q      (data_q),
  .dir_q       (dir_q),
  .wr_data_evt (wr_data_evt),
  .wr_dir_evt  (wr_dir_evt)
);

// File: tb/test_gpmux_port.sv
`timescale 1ns/1ps
module test_gpmux_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0, bus_sel_dir = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, pin_in = '0;
  logic [7:0] pad_out, pad_oe, pad_od;
  logic       en_can_a = 0, can_a_tx = 0, can_a_rx;
  logic       en_twi0 = 0, twi0_scl_o = 0, twi0_sda_o = 0, twi0_scl_i, twi0_sda_i;
  logic       en_can_b = 0, can_b_tx = 0, can_b_rx;
  logic       en_twi1 = 0, twi1_scl_o = 0, twi1_sda_o = 0, twi1_scl_i, twi1_sda_i;
  logic [3:0] cs_en = '0, cs_val = '0;
  logic       en_uart = 0, uart_tx = 0, uart_rx;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gpmux_port i_gpmux_port (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_sel_dir = sel; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    bus_sel_dir = sel;
    #1 v = bus_rdata;
  endtask

  task automatic clear_fn();
    en_can_a = 0; en_twi0 = 0; en_can_b = 0; en_twi1 = 0; en_uart = 0;
    cs_en = '0; cs_val = '0; can_a_tx = 0; can_b_tx = 0; uart_tx = 0;
    twi0_scl_o = 0; twi0_sda_o = 0; twi1_scl_o = 0; twi1_sda_o = 0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1 check("R1 oe", pad_oe, 8'h00);
    rd(1'b1, v); check("R1 dir", v, 8'h00);
    rd(1'b0, v); check("R1 data", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R2 R4 dir read", v, 8'hF7);
    wr(1'b0, 8'hAD);
    rd(1'b0, v); check("R2 R4 data read", v, 8'hA5);
  endtask

  task automatic t_read_mix();
    logic [7:0] v;
    wr(1'b1, 8'h0F);
    pin_in = 8'h5A;
    rd(1'b0, v); check("R3 mixed read", v, 8'h55);
    pin_in = 8'hFF;
    rd(1'b0, v); check("R3 R4 pin follow", v, 8'hF5);
    pin_in = 8'h00;
  endtask

  task automatic t_gpio();
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'hA5);
    #1;
    check("R5 out", pad_out, 8'hA5);
    check("R5 oe", pad_oe, 8'hF7);
    check("R5 od", pad_od, 8'h00);
    wr(1'b1, 8'h00);
    #1 check("R5 oe off", pad_oe, 8'h00);
  endtask

  task automatic t_grp76();
    wr(1'b1, 8'hFF); wr(1'b0, 8'h00);
    pin_in = 8'h00;
    en_can_b = 1; can_b_tx = 1; #1;
    check("R6 canb", {pad_out[7], pad_oe[7:6], pad_od[7]}, 4'b1100);
    check("R11 canb rx", can_b_rx, 1'b0);
    en_twi0 = 1; twi0_scl_o = 1; twi0_sda_o = 0; #1;
    check("R6 R10 twi0 od", pad_od[7:6], 2'b11);
    check("R10 twi0 oe", pad_oe[7:6], 2'b01);
    check("R10 twi0 out", pad_out[7:6], 2'b00);
    check("R11 canb idle", can_b_rx, 1'b1);
    check("R11 twi0 in", {twi0_scl_i, twi0_sda_i}, 2'b00);
    en_can_a = 1; can_a_tx = 0; #1;
    check("R6 cana", {pad_out[7], pad_oe[7:6], pad_od[7:6]}, 5'b01000);
    check("R11 twi0 idle", {twi0_scl_i, twi0_sda_i}, 2'b11);
    check("R11 cana rx", can_a_rx, 1'b0);
    clear_fn();
    check("R6 back gpio", {pad_oe[7:6], pad_od[7:6]}, 4'b1100);
  endtask

  task automatic t_grp54();
    wr(1'b1, 8'h00);
    cs_en = 4'b0101; cs_val = 4'b0100; #1;
    check("R7 csel", {pad_out[5:4], pad_oe[5:4], pad_od[5:4]}, 6'b101100);
    en_twi1 = 1; twi1_scl_o = 0; twi1_sda_o = 1; #1;
    check("R7 R10 twi1", {pad_out[5:4], pad_oe[5:4], pad_od[5:4]}, 6'b001011);
    clear_fn();
  endtask

  task automatic t_bit2();
    wr(1'b1, 8'hFF); wr(1'b0, 8'h00);
    cs_en[1] = 1; cs_val[1] = 1; #1;
    check("R8 csel1", {pad_out[2], pad_oe[2]}, 2'b11);
    cs_en[1] = 0; #1;
    check("R8 gpio", {pad_out[2], pad_oe[2]}, 2'b01);
    clear_fn();
  endtask

  task automatic t_grp10();
    wr(1'b1, 8'h00);
    en_uart = 1; uart_tx = 1; cs_en[3] = 1; cs_val[3] = 1; #1;
    check("R9 uart", {pad_out[1], pad_oe[1:0]}, 3'b110);
    en_uart = 0; #1;
    check("R9 csel3", {pad_out[0], pad_oe[0], pad_oe[1]}, 3'b110);
    clear_fn();
  endtask

  task automatic t_rx();
    en_uart = 1; pin_in = 8'h00; #1;
    check("R11 uart rx low", uart_rx, 1'b0);
    pin_in = 8'h01; #1;
    check("R11 uart rx high", uart_rx, 1'b1);
    en_uart = 0; pin_in = 8'h00; #1;
    check("R11 uart idle", uart_rx, 1'b1);
    en_twi1 = 1; #1;
    check("R11 twi1 in", {twi1_scl_i, twi1_sda_i}, 2'b00);
    en_twi1 = 0; #1;
    check("R11 twi1 idle", {twi1_scl_i, twi1_sda_i}, 2'b11);
    clear_fn();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_read_mix();
    t_gpio();
    t_grp76();
    t_grp54();
    t_bit2();
    t_grp10();
    t_rx();
    finish_run();
  end

endmodule